// File: doc/BRIEF.md
# Secondary Interrupt Combiner with Passthrough Lines

This block collects 32 level-sensitive interrupt inputs and presents them to an upstream interrupt controller in two ways. A software-programmable enable mask selects which inputs contribute to one combined request, which is driven on output line 31. Separately, a passthrough-enable register can route any of inputs 21 to 30 straight onto the output line with the same number. The upstream controller can then treat those sources individually instead of through the combined line.

Software reaches the block through single-cycle read and write strobes. The register index is the byte offset within a 4 KB window, shifted right by two. The enable mask and the passthrough-enable register are both changed through separate set and clear locations, so one write never disturbs unrelated bits. A software-held flag, the soft interrupt, is merged into input bit 0. All outputs are registered.

Top module: `sec_irq_ctl`

## Requirements
- R1: A read at index 1 returns the raw level: `irq_in` with the soft flag ORed into bit 0.
- R2: `irq_out[31]` is high exactly when the raw level ANDed with the enable mask is nonzero.
- R3: A read at index 0 returns the raw level ANDed with the enable mask, and a read at index 2 returns the enable mask.
- R4: A write at index 2 ORs `wdata` into the enable mask. A write at index 3 clears every enable bit that is set in `wdata`.
- R5: A write at index 8 ORs `wdata & 0x7FE00000` into the passthrough-enable register, so only bits 21 to 30 can be set. A write at index 9 clears the bits set in `wdata`. A read at index 8 returns the register.
- R6: For lines 21 to 30, `irq_out[i]` equals raw bit i while passthrough-enable bit i is set, and is low otherwise. `irq_out[20:0]` is always low.
- R7: A nonzero write at index 4 sets the soft flag, and a nonzero write at index 5 clears it. A zero write to either index does nothing. A read at index 4 returns raw bit 0 in bit 0, with the other bits zero.
- R8: Reads at any index other than 0, 1, 2, 4 and 8 return zero. Writes at any index other than 2, 3, 4, 5, 8 and 9 change no state.
- R9: While `rst_n` is low, the soft flag, the enable mask and the passthrough-enable register are cleared and `irq_out` is all zero.
- R10: `irq_out` changes at the first rising edge after an input change is sampled. After a write, it changes at the rising edge that follows the edge that samples the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 32 | Level-sensitive interrupt inputs |
| wr_en | input | 1 | Single-cycle write strobe |
| rd_en | input | 1 | Read strobe; `rdata` is zero when low |
| reg_idx | input | 10 | Register index (byte offset >> 2) |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational from `reg_idx` |
| irq_out | output | 32 | Line 31 combined request; lines 21-30 passthrough; rest low |

## Verification
The bench builds the block with its default parameters: 32 lines, a 10-bit index, the combined request on line 31 and passthrough on lines 21 to 30. With these values every input bit can be walked one at a time and every one of the 1024 register indices can be read and written. This covers the decode exhaustively, including every unmapped index. Each line is swept with its enable and passthrough bit both on and off, and the expected output and read data are computed arithmetically from a small shadow of the three software-held registers.

// File: rtl/sec_irq_ctl.sv
module sec_irq_ctl #(
  parameter int N         = 32,
  parameter int IDX_W     = 10,
  parameter int COMB_LINE = 31,
  parameter int PASS_LO   = 21,
  parameter int PASS_HI   = 30
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     irq_in,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] reg_idx,
  input  logic [N-1:0]     wdata,
  output logic [N-1:0]     rdata,
  output logic [N-1:0]     irq_out
);
  localparam logic [IDX_W-1:0] I_STAT   = IDX_W'(0);
  localparam logic [IDX_W-1:0] I_RAW    = IDX_W'(1);
  localparam logic [IDX_W-1:0] I_ENSET  = IDX_W'(2);
  localparam logic [IDX_W-1:0] I_ENCLR  = IDX_W'(3);
  localparam logic [IDX_W-1:0] I_SWSET  = IDX_W'(4);
  localparam logic [IDX_W-1:0] I_SWCLR  = IDX_W'(5);
  localparam logic [IDX_W-1:0] I_PTSET  = IDX_W'(8);
  localparam logic [IDX_W-1:0] I_PTCLR  = IDX_W'(9);

  function automatic logic [N-1:0] pass_window();
    logic [N-1:0] m;
    m = '0;
    for (int i = PASS_LO; i <= PASS_HI; i++) m[i] = 1'b1;
    return m;
  endfunction

  localparam logic [N-1:0] PASS_MASK = pass_window();

  logic [N-1:0] en_q, pass_q, raw, out_d;
  logic         soft_q;

  assign raw = irq_in | {{(N-1){1'b0}}, soft_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= '0;
      pass_q <= '0;
      soft_q <= 1'b0;
    end else if (wr_en) begin
      case (reg_idx)
        I_ENSET: en_q   <= en_q | wdata;
        I_ENCLR: en_q   <= en_q & ~wdata;
        I_SWSET: if (|wdata) soft_q <= 1'b1;
        I_SWCLR: if (|wdata) soft_q <= 1'b0;
        I_PTSET: pass_q <= pass_q | (wdata & PASS_MASK);
        I_PTCLR: pass_q <= pass_q & ~wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      case (reg_idx)
        I_STAT:  rdata = raw & en_q;
        I_RAW:   rdata = raw;
        I_ENSET: rdata = en_q;
        I_SWSET: rdata = {{(N-1){1'b0}}, raw[0]};
        I_PTSET: rdata = pass_q;
        default: rdata = '0;
      endcase
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_line
    if (i == COMB_LINE) begin : g_comb
      assign out_d[i] = |(raw & en_q);
    end else if (i >= PASS_LO && i <= PASS_HI) begin : g_pass
      assign out_d[i] = pass_q[i] & raw[i];
    end else begin : g_idle
      assign out_d[i] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) irq_out <= '0;
    else        irq_out <= out_d;
  end
endmodule

// File: rtl/sec_irq_ctl_chk.sv
module sec_irq_ctl_chk #(
  parameter int N     = 32,
  parameter int IDX_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N-1:0]     irq_in,
  input logic             wr_en,
  input logic [IDX_W-1:0] reg_idx,
  input logic [N-1:0]     wdata,
  input logic [N-1:0]     irq_out,
  input logic [N-1:0]     en_q,
  input logic [N-1:0]     pass_q,
  input logic             soft_q
);
  logic mapped_wr;
  assign mapped_wr = reg_idx inside {IDX_W'(2), IDX_W'(3), IDX_W'(4),
                                     IDX_W'(5), IDX_W'(8), IDX_W'(9)};

  assert_pass_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pass_q & 32'h801F_FFFF) == '0);

  assert_low_lines_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out[20:0] == '0);

  assert_pass_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_out[30:21] & ~($past(pass_q[30:21]) & $past(irq_in[30:21]))) == '0);

  assert_comb_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |=> !irq_out[31]);

  assert_soft_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_idx == IDX_W'(4) && wdata != '0) |=> soft_q);

  assert_unmapped_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !mapped_wr) |=> ($stable(en_q) && $stable(pass_q) && $stable(soft_q)));
endmodule

bind sec_irq_ctl sec_irq_ctl_chk #(.N(N), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .wr_en(wr_en), .reg_idx(reg_idx),
  .wdata(wdata), .irq_out(irq_out), .en_q(en_q), .pass_q(pass_q), .soft_q(soft_q)
);

// File: tb/test_sec_irq_ctl.sv
module test_sec_irq_ctl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq_in = '0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [9:0]  reg_idx = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, irq_out;

  int checks = 0;
  int fails = 0;
  logic [31:0] m_en = '0, m_pass = '0;
  logic        m_soft = 1'b0;

  always #5 clk = ~clk;

  sec_irq_ctl i_sec_irq_ctl (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .wr_en(wr_en), .rd_en(rd_en),
    .reg_idx(reg_idx), .wdata(wdata), .rdata(rdata), .irq_out(irq_out)
  );

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [31:0] raw_of(logic [31:0] in);
    return in | {31'b0, m_soft};
  endfunction

  function automatic logic [31:0] exp_out(logic [31:0] in);
    logic [31:0] r, o;
    r = raw_of(in);
    o = '0;
    o[31] = (r & m_en) != 0;
    o[30:21] = r[30:21] & m_pass[30:21];
    return o;
  endfunction

  task automatic wr(int idx, logic [31:0] v);
    @(negedge clk);
    wr_en = 1'b1; reg_idx = 10'(idx); wdata = v;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
    case (idx)
      2: m_en = m_en | v;
      3: m_en = m_en & ~v;
      4: if (v != 0) m_soft = 1'b1;
      5: if (v != 0) m_soft = 1'b0;
      8: m_pass = m_pass | (v & 32'h7FE0_0000);
      9: m_pass = m_pass & ~v;
      default: ;
    endcase
  endtask

  task automatic rd(int idx, output logic [31:0] v);
    rd_en = 1'b1; reg_idx = 10'(idx);
    #1 v = rdata;
    rd_en = 1'b0;
  endtask

  task automatic drive_in(logic [31:0] v);
    @(negedge clk);
    irq_in = v;
    @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    chk("R9 outputs in reset", irq_out, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 outputs after reset", irq_out, 32'h0);
    rd(2, v); chk("R9 enable cleared", v, 32'h0);
    rd(8, v); chk("R9 passthrough cleared", v, 32'h0);
    rd(4, v); chk("R9 soft cleared", v, 32'h0);

    for (int i = 0; i < 32; i++) begin
      drive_in(32'h1 << i);
      rd(1, v); chk("R1 raw walk", v, 32'h1 << i);
      rd(0, v); chk("R3 status masked off", v, 32'h0);
      chk("R2 combined low, no enable", irq_out, 32'h0);
    end

    for (int i = 0; i < 32; i++) begin
      wr(2, 32'h1 << i);
      rd(2, v); chk("R4 enable set accumulates", v, m_en);
      drive_in(32'h1 << i);
      rd(0, v); chk("R3 status", v, 32'h1 << i);
      chk("R2 combined high", irq_out, exp_out(irq_in));
      drive_in(32'h0);
      chk("R2 combined drops", irq_out, 32'h0);
    end

    for (int i = 0; i < 32; i += 2) wr(3, 32'h1 << i);
    rd(2, v); chk("R4 enable clear", v, 32'hAAAA_AAAA);
    for (int i = 0; i < 32; i++) begin
      drive_in(32'h1 << i);
      chk("R2 combined odd lines only", irq_out, exp_out(irq_in));
    end
    wr(3, 32'hFFFF_FFFF);
    rd(2, v); chk("R4 enable all clear", v, 32'h0);

    wr(8, 32'hFFFF_FFFF);
    rd(8, v); chk("R5 passthrough set masked", v, 32'h7FE0_0000);
    for (int i = 0; i < 32; i++) begin
      drive_in(32'h1 << i);
      chk("R6 passthrough walk", irq_out, exp_out(irq_in));
    end
    wr(9, 32'h5540_0000);
    rd(8, v); chk("R5 passthrough clear", v, 32'h2AA0_0000);
    for (int i = 0; i < 32; i++) begin
      drive_in(32'h1 << i);
      chk("R6 partly gated passthrough", irq_out, exp_out(irq_in));
    end
    drive_in(32'hFFFF_FFFF);
    chk("R6 all inputs high", irq_out, 32'h2AA0_0000);

    drive_in(32'h0000_0000);
    wr(4, 32'h0);
    rd(4, v); chk("R7 zero write no set", v, 32'h0);
    wr(2, 32'h1);
    wr(4, 32'h0000_0100);
    rd(4, v); chk("R7 soft set", v, 32'h1);
    rd(1, v); chk("R1 soft in raw", v, 32'h1);
    @(negedge clk);
    chk("R2 soft drives combined", irq_out, 32'h8000_0000);
    wr(5, 32'h0);
    rd(4, v); chk("R7 zero clear no effect", v, 32'h1);
    wr(5, 32'h8000_0000);
    rd(4, v); chk("R7 soft clear", v, 32'h0);
    drive_in(32'h1);
    rd(4, v); chk("R7 read follows input bit 0", v, 32'h1);
    drive_in(32'h0);

    wr(2, 32'h0F00_F00F);
    wr(8, 32'h0060_0000);
    for (int i = 0; i < 1024; i++) begin
      if (!(i inside {2, 3, 4, 5, 8, 9})) begin
        @(negedge clk);
        wr_en = 1'b1; reg_idx = 10'(i); wdata = 32'hFFFF_FFFF;
      end
    end
    @(negedge clk);
    wr_en = 1'b0;
    rd(2, v); chk("R8 enable untouched", v, m_en);
    rd(8, v); chk("R8 passthrough untouched", v, m_pass);
    rd(4, v); chk("R8 soft untouched", v, 32'h0);
    drive_in(32'hFFFF_FFFF);
    for (int i = 0; i < 1024; i++) begin
      if (!(i inside {0, 1, 2, 4, 8})) begin
        rd(i, v); chk("R8 unmapped read zero", v, 32'h0);
      end
    end
    rd(1, v); chk("R1 raw all high", v, 32'hFFFF_FFFF);

    drive_in(32'h0);
    wr(3, 32'hFFFF_FFFF);
    wr(9, 32'hFFFF_FFFF);
    @(negedge clk);
    irq_in = 32'h4000_0001;
    chk("R10 input not yet seen", irq_out, 32'h0);
    @(negedge clk);
    chk("R10 input gated one edge later", irq_out, 32'h0);
    wr(2, 32'h1);
    chk("R10 write edge output old", irq_out, 32'h0);
    @(negedge clk);
    chk("R10 combined one edge after write", irq_out, 32'h8000_0000);
    wr(8, 32'h4000_0000);
    chk("R10 passthrough not yet", irq_out, 32'h8000_0000);
    @(negedge clk);
    chk("R10 passthrough on newly enabled", irq_out, 32'hC000_0000);

    rst_n = 1'b0;
    @(negedge clk);
    chk("R9 reset clears outputs", irq_out, 32'h0);
    rd(2, v); chk("R9 reset clears enable", v, 32'h0);

    summary();
    $finish;
  end
endmodule